// File: doc/BRIEF.md
# Dual PWM Coil Drive Generator

This block produces the pulse-width modulated drive for a two-coil stepper motor. Two 10-bit pulse generators share one operating clock, which is taken from the peripheral clock through a prescaler with a fixed, non-binary table of divide ratios. Generator A drives coil A and generator B drives coil B. Each of the four coil pins has a 3-bit routing field that picks a static level, the coil's pulse, or its inverse.

Software stops the block, writes the compare values and routing fields into shadow registers, and requests a buffer transfer. It then picks a prescaler code and sets the run bit. A hardware trigger input can set the run bit as well. Generator B always starts one peripheral clock after generator A, so the two coils never switch on the same edge. Shadow values move into the active registers only at a counter wrap, so a running period is never cut short. While the block is stopped, the transfer happens at once.

Top module: `stepdrv_top`

## Requirements
- R1: After reset the run bit is 0, the prescaler code is 0000 (divide by 1), all active compare values and routing fields are 0, and every coil pin is low.
- R2: With prescaler code bit 3 set, the low three bits 000..111 select divide ratios 2, 8, 10, 12, 16, 20, 24 and 32 in that order.
- R3: With prescaler code bit 3 clear, the low three bits 000..111 select divide ratios 1, 2, 4, 6, 8, 10, 12 and 16 in that order.
- R4: The clock edge that sets the run bit starts generator A at count 0. Generator B starts at count 0 exactly one peripheral clock later and then follows generator A's count with a lag of one peripheral clock.
- R5: Clearing the run bit stops both generators and clears their counts, so the next start begins again from count 0.
- R6: A high trigger sets the run bit when the run bit is 0, and this wins over a software write of 0 in the same cycle. While the run bit is 1, the trigger has no effect and a software write of 0 clears the bit.
- R7: Each counter steps from 0 to 1023 and wraps, advancing once per prescaled tick. A generator output is high while its count is below its compare value, so a compare value of 0 keeps it low.
- R8: Pin i uses bits [3i+2:3i] of the routing field. Pins 0 and 1 belong to coil A (generator A), and pins 2 and 3 to coil B (generator B). Code 000 is static low, 001 static high, 010 the coil pulse, and 011 the inverted coil pulse. Codes 100..111 drive low.
- R9: While the run bit is 0, every pin whose code is 010 or 011 is low.
- R10: A shadow write followed by a transfer request moves compare values and routing fields into use. While the run bit is 1, this happens at the clock edge where generator A wraps from 1023 to 0. While the run bit is 0, it happens on the second clock edge after the request.
- R11: A prescaler write while the run bit is 1 is ignored, and the divide ratio in use does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_wr | input | 1 | Write strobe for the prescaler code |
| presc_code | input | 4 | Prescaler code to write |
| ce_wr | input | 1 | Write strobe for the run bit |
| ce_wdata | input | 1 | Run bit value to write |
| trig | input | 1 | Hardware start trigger |
| shd_wr | input | 1 | Write strobe for the shadow compare values and routing fields |
| shd_cmp_a | input | 10 | Shadow compare value for generator A |
| shd_cmp_b | input | 10 | Shadow compare value for generator B |
| shd_sel | input | 12 | Shadow routing fields, 3 bits per pin |
| xfer_req | input | 1 | Requests a shadow-to-active transfer |
| coil_pins | output | 4 | Coil drive pins |

## Verification
The hardest case to reach is a transfer that is pending while the block runs. The bench has to show that the new compare value stays unused for the rest of the current 1024-count period and is used from the next one. To get there, the stimulus starts a divide-by-1 run, writes a larger compare value early in the period, and then samples the coil A pin at the same count in two periods in a row: low before the wrap, high after it. The one-clock lag of generator B is checked at the first counts after start for every prescaler code, so each divide ratio also shows up in where the two coils switch.

// File: rtl/stepdrv_pkg.sv
package stepdrv_pkg;

    localparam int CNT_W  = 10;
    localparam int NPIN   = 4;
    localparam int SEL_W  = 3;
    localparam int CODE_W = 4;
    localparam int DIV_W  = 6;

    localparam logic [SEL_W-1:0] SEL_LOW  = 3'b000;
    localparam logic [SEL_W-1:0] SEL_HIGH = 3'b001;
    localparam logic [SEL_W-1:0] SEL_PWM  = 3'b010;
    localparam logic [SEL_W-1:0] SEL_PWMN = 3'b011;

    typedef struct packed {
        logic [CNT_W-1:0]      cmp_a;
        logic [CNT_W-1:0]      cmp_b;
        logic [NPIN*SEL_W-1:0] sel;
    } drv_cfg_t;

    // Prescaler code to divide ratio; bit 3 picks the coarse table.
    function automatic logic [DIV_W-1:0] div_ratio(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            4'b0000: r = 6'd1;
            4'b0001: r = 6'd2;
            4'b0010: r = 6'd4;
            4'b0011: r = 6'd6;
            4'b0100: r = 6'd8;
            4'b0101: r = 6'd10;
            4'b0110: r = 6'd12;
            4'b0111: r = 6'd16;
            4'b1000: r = 6'd2;
            4'b1001: r = 6'd8;
            4'b1010: r = 6'd10;
            4'b1011: r = 6'd12;
            4'b1100: r = 6'd16;
            4'b1101: r = 6'd20;
            4'b1110: r = 6'd24;
            default: r = 6'd32;
        endcase
        return r;
    endfunction

    // Level of one pin for its routing code.
    function automatic logic pin_level(input logic [SEL_W-1:0] code,
                                       input logic pwm, input logic run);
        logic v;
        case (code)
            SEL_HIGH: v = 1'b1;
            SEL_PWM:  v = run & pwm;
            SEL_PWMN: v = run & ~pwm;
            default:  v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/stepdrv_presc.sv
module stepdrv_presc
    import stepdrv_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pcnt;

    assign tick = run && (pcnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/stepdrv_gen.sv
module stepdrv_gen
    import stepdrv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         pwm,
    output logic         wrap
);
    assign pwm  = en && (cnt < cmp);
    assign wrap = en && tick && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stepdrv_route.sv
module stepdrv_route
    import stepdrv_pkg::*;
#(
    parameter int N  = NPIN,
    parameter int SW = SEL_W
) (
    input  logic [N*SW-1:0] sel,
    input  logic [1:0]      pwm,
    input  logic            run,
    output logic [N-1:0]    pins
);
    localparam int PINS_PER_COIL = N / 2;

    for (genvar i = 0; i < N; i++) begin : g_pin
        localparam int COIL = i / PINS_PER_COIL;
        assign pins[i] = pin_level(sel[i*SW +: SW], pwm[COIL], run);
    end
endmodule

// File: rtl/stepdrv_top.sv
module stepdrv_top
    import stepdrv_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int N  = NPIN,
    parameter int SW = SEL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           presc_wr,
    input  logic [3:0]     presc_code,
    input  logic           ce_wr,
    input  logic           ce_wdata,
    input  logic           trig,
    input  logic           shd_wr,
    input  logic [CW-1:0]  shd_cmp_a,
    input  logic [CW-1:0]  shd_cmp_b,
    input  logic [N*SW-1:0] shd_sel,
    input  logic           xfer_req,
    output logic [N-1:0]   coil_pins
);
    logic              ce_q;
    logic              en_b_q;
    logic              tick_a;
    logic              tick_b_q;
    logic [CODE_W-1:0] presc_q;
    logic [DIV_W-1:0]  div;
    drv_cfg_t          shd_q;
    drv_cfg_t          act_q;
    logic              pend_q;
    logic              do_xfer;
    logic [CW-1:0]     cnt_a;
    logic [CW-1:0]     cnt_b;
    logic [1:0]        pwm;
    logic              wrap_a;
    logic              wrap_b;
    logic [N*SW-1:0]   sel_act;

    // Run bit: a trigger while stopped beats a same-cycle software write.
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= 1'b0;
        end else if (trig && !ce_q) begin
            ce_q <= 1'b1;
        end else if (ce_wr) begin
            ce_q <= ce_wdata;
        end
    end

    // Prescaler code is locked while running.
    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
        end else if (presc_wr && !ce_q) begin
            presc_q <= presc_code;
        end
    end

    assign div = div_ratio(presc_q);

    // Generator B lags A by one peripheral clock in both enable and tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_b_q   <= 1'b0;
            tick_b_q <= 1'b0;
        end else begin
            en_b_q   <= ce_q;
            tick_b_q <= tick_a;
        end
    end

    // Shadow and active configuration.
    assign do_xfer = pend_q && (!ce_q || wrap_a);

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_q  <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (shd_wr) begin
                shd_q.cmp_a <= shd_cmp_a;
                shd_q.cmp_b <= shd_cmp_b;
                shd_q.sel   <= shd_sel;
            end
            if (do_xfer) begin
                act_q <= shd_q;
            end
            if (xfer_req) begin
                pend_q <= 1'b1;
            end else if (do_xfer) begin
                pend_q <= 1'b0;
            end
        end
    end

    stepdrv_presc #(.W(DIV_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ce_q),
        .div  (div),
        .tick (tick_a)
    );

    stepdrv_gen #(.W(CW)) u_gen_a (
        .clk  (clk),
        .rst  (rst),
        .en   (ce_q),
        .tick (tick_a),
        .cmp  (act_q.cmp_a),
        .cnt  (cnt_a),
        .pwm  (pwm[0]),
        .wrap (wrap_a)
    );

    stepdrv_gen #(.W(CW)) u_gen_b (
        .clk  (clk),
        .rst  (rst),
        .en   (en_b_q),
        .tick (tick_b_q),
        .cmp  (act_q.cmp_b),
        .cnt  (cnt_b),
        .pwm  (pwm[1]),
        .wrap (wrap_b)
    );

    assign sel_act = act_q.sel;

    stepdrv_route #(.N(N), .SW(SW)) u_route (
        .sel  (sel_act),
        .pwm  (pwm),
        .run  (ce_q),
        .pins (coil_pins)
    );
endmodule

// File: rtl/stepdrv_chk.sv
module stepdrv_chk
    import stepdrv_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  trig,
    input logic                  ce,
    input logic                  en_b,
    input logic [CNT_W-1:0]      cnt_a,
    input logic [CNT_W-1:0]      cnt_b,
    input logic [CODE_W-1:0]     presc_q,
    input logic [NPIN*SEL_W-1:0] sel_act,
    input logic [NPIN-1:0]       coil_pins
);
    logic [NPIN-1:0] pwm_mask;

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            pwm_mask[i] = (sel_act[i*SEL_W +: SEL_W] == SEL_PWM) ||
                          (sel_act[i*SEL_W +: SEL_W] == SEL_PWMN);
        end
    end

    p_gen_b_lag_r4: assert property (@(posedge clk) disable iff (rst)
        (ce && en_b) |-> (cnt_b == $past(cnt_a)));

    p_trig_start_r6: assert property (@(posedge clk) disable iff (rst)
        (trig && !ce) |=> ce);

    p_stopped_low_r9: assert property (@(posedge clk) disable iff (rst)
        !ce |-> ((coil_pins & pwm_mask) == '0));

    p_presc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ce |=> $stable(presc_q));

    p_static_high_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_act[SEL_W-1:0] == SEL_HIGH) |-> coil_pins[0]);
endmodule

bind stepdrv_top stepdrv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .ce        (ce_q),
    .en_b      (en_b_q),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .presc_q   (presc_q),
    .sel_act   (sel_act),
    .coil_pins (coil_pins)
);

// File: tb/sim_stepdrv_top.sv
`timescale 1ns/1ps
module sim_stepdrv_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        presc_wr = 1'b0;
    logic [3:0]  presc_code = '0;
    logic        ce_wr = 1'b0;
    logic        ce_wdata = 1'b0;
    logic        trig = 1'b0;
    logic        shd_wr = 1'b0;
    logic [9:0]  shd_cmp_a = '0;
    logic [9:0]  shd_cmp_b = '0;
    logic [11:0] shd_sel = '0;
    logic        xfer_req = 1'b0;
    logic [3:0]  coil_pins;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stepdrv_top u0 (
        .clk(clk), .rst(rst), .presc_wr(presc_wr), .presc_code(presc_code),
        .ce_wr(ce_wr), .ce_wdata(ce_wdata), .trig(trig), .shd_wr(shd_wr),
        .shd_cmp_a(shd_cmp_a), .shd_cmp_b(shd_cmp_b), .shd_sel(shd_sel),
        .xfer_req(xfer_req), .coil_pins(coil_pins)
    );

    // ---------- reference from the requirements ----------
    function automatic int ratio(input logic [3:0] c);
        int lo_t[8] = '{1, 2, 4, 6, 8, 10, 12, 16};
        int hi_t[8] = '{2, 8, 10, 12, 16, 20, 24, 32};
        return c[3] ? hi_t[c[2:0]] : lo_t[c[2:0]];
    endfunction

    function automatic logic lvl(input logic [2:0] code, input logic p, input logic run);
        if (code == 3'b001) return 1'b1;
        if (code == 3'b010) return run & p;
        if (code == 3'b011) return run & ~p;
        return 1'b0;
    endfunction

    function automatic logic [11:0] mk_sel(input logic [2:0] c0, input logic [2:0] c1,
                                           input logic [2:0] c2, input logic [2:0] c3);
        return {c3, c2, c1, c0};
    endfunction

    // Pins k edges after the starting edge.
    function automatic logic [3:0] run_pins(input int k, input int dv, input int ca,
                                            input int cb, input logic [11:0] sel);
        logic pa, pb;
        logic [3:0] r;
        pa = ((k / dv) % 1024) < ca;
        pb = (k >= 1) && ((((k - 1) / dv) % 1024) < cb);
        for (int i = 0; i < 4; i++) r[i] = lvl(sel[3*i +: 3], (i < 2) ? pa : pb, 1'b1);
        return r;
    endfunction

    // ---------- checking ----------
    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: coil_pins=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            if (sb[0].at < cyc) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s: sample missed, actual=none expected=%b", sb[0].tag, sb[0].exp);
            end else begin
                check(sb[0].tag, coil_pins, sb[0].exp);
            end
            void'(sb.pop_front());
        end
    end

    // ---------- driver tasks (drive at the falling edge) ----------
    task automatic load_cfg(input int ca, input int cb, input logic [11:0] sel);
        @(negedge clk);
        shd_wr = 1'b1; shd_cmp_a = ca[9:0]; shd_cmp_b = cb[9:0]; shd_sel = sel;
        xfer_req = 1'b1;
        @(negedge clk);
        shd_wr = 1'b0; xfer_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_presc(input logic [3:0] c);
        @(negedge clk);
        presc_wr = 1'b1; presc_code = c;
        @(negedge clk);
        presc_wr = 1'b0;
    endtask

    task automatic write_ce(input logic v);
        @(negedge clk);
        ce_wr = 1'b1; ce_wdata = v;
        @(negedge clk);
        ce_wr = 1'b0;
    endtask

    // Pushes expectations at offsets ks, then sets the run bit; returns at k = 0.
    task automatic start_run(input int dv, input int ca, input int cb, input logic [11:0] sel,
                             input int ks[$], input string tag);
        int c0;
        @(negedge clk);
        c0 = cyc + 1;
        foreach (ks[j]) sb.push_back('{c0 + ks[j], run_pins(ks[j], dv, ca, cb, sel), tag});
        ce_wr = 1'b1; ce_wdata = 1'b1;
        @(negedge clk);
        ce_wr = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    // ---------- stimulus ----------
    initial begin
        logic [11:0] s_all;
        logic [11:0] s_ab;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pins low", coil_pins, 4'b0000);

        // R8/R9: static codes and stopped PWM codes.
        load_cfg(5, 5, mk_sel(3'b001, 3'b000, 3'b010, 3'b011));
        check("R8 static high/low, R9 stopped pwm low", coil_pins, 4'b0001);
        @(negedge clk);
        shd_wr = 1'b1; shd_sel = mk_sel(3'b000, 3'b001, 3'b110, 3'b001);
        @(negedge clk);
        shd_wr = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 shadow without transfer unused", coil_pins, 4'b0001);
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        check("R10 stopped transfer one edge early", coil_pins, 4'b0001);
        @(negedge clk);
        check("R8 codes 110/001 after stopped transfer", coil_pins, 4'b1010);

        // R4/R7: divide-by-1 run from reset prescaler code (R1).
        s_all = mk_sel(3'b010, 3'b011, 3'b010, 3'b011);
        load_cfg(4, 2, s_all);
        start_run(1, 4, 2, s_all, '{0, 1, 2, 3, 4, 5, 1023, 1024, 1025, 1026},
                  "R1 R4 R7 start lag and wrap");
        drain();
        write_ce(1'b0);
        check("R9 stop forces pwm pins low", coil_pins, 4'b0000);

        // R5: stop mid-period, restart from zero.
        load_cfg(1, 1, s_all);
        start_run(1, 1, 1, s_all, '{300}, "R5 first run");
        drain();
        write_ce(1'b0);
        start_run(1, 1, 1, s_all, '{0, 1, 2}, "R5 restart from count 0");
        drain();
        write_ce(1'b0);

        // R2/R3: every prescaler code.
        for (int c = 0; c < 16; c++) begin
            int dv;
            dv = ratio(c[3:0]);
            set_presc(c[3:0]);
            start_run(dv, 1, 1, s_all, '{dv - 1, dv, dv + 1},
                      c[3] ? "R2 coarse divide table" : "R3 fine divide table");
            drain();
            write_ce(1'b0);
        end

        // R11: prescaler write while running is ignored.
        set_presc(4'b1001);
        start_run(8, 1, 1, s_all, '{7, 8, 9}, "R11 divide kept at 8");
        @(negedge clk);
        presc_wr = 1'b1; presc_code = 4'b0000;
        @(negedge clk);
        presc_wr = 1'b0;
        drain();
        write_ce(1'b0);
        set_presc(4'b0000);

        // R10/R7: transfer while running waits for the wrap; cmp 0 keeps coil B low.
        s_ab = mk_sel(3'b010, 3'b000, 3'b010, 3'b000);
        load_cfg(4, 0, s_ab);
        start_run(1, 4, 0, s_ab, '{1, 500}, "R7 R10 old compare in first period");
        repeat (10) @(negedge clk);
        shd_wr = 1'b1; shd_cmp_a = 10'd600; shd_cmp_b = 10'd0; shd_sel = s_ab;
        xfer_req = 1'b1;
        @(negedge clk);
        shd_wr = 1'b0; xfer_req = 1'b0;
        drain();
        repeat (1024 + 500 - 502) @(negedge clk);
        check("R10 new compare after wrap", coil_pins, 4'b0001);
        write_ce(1'b0);

        // R6: trigger behaviour, watched on pin 0 with compare 1023.
        load_cfg(1023, 0, mk_sel(3'b010, 3'b000, 3'b000, 3'b000));
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check("R6 trigger starts", coil_pins, 4'b0001);
        @(negedge clk);
        trig = 1'b1; ce_wr = 1'b1; ce_wdata = 1'b0;
        @(negedge clk);
        trig = 1'b0; ce_wr = 1'b0;
        check("R6 trigger ignored while running, clear wins", coil_pins, 4'b0000);
        @(negedge clk);
        trig = 1'b1; ce_wr = 1'b1; ce_wdata = 1'b0;
        @(negedge clk);
        trig = 1'b0; ce_wr = 1'b0;
        check("R6 trigger beats same-cycle clear", coil_pins, 4'b0001);
        write_ce(1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule